// File: doc/BRIEF.md
# Key-Driven Four-Digit Decimal Entry

This block holds a four-digit decimal number that an operator edits with three push-buttons, and it drives that number onto a multiplexed seven-segment display. Editing always happens at the rightmost digit. One key raises that digit by one and another lowers it by one. Each digit wraps within 0 to 9 and never carries into or borrows from its neighbour. The third key moves the whole number one place to the left. The leftmost digit is lost and the rightmost becomes 0, so the operator can enter the next digit there.

Each raw key line is active low and asynchronous to the clock. It goes through its own conditioner: a two-flop synchroniser, then a four-state debounce machine named `DB_RELEASED`, `DB_PRESS_CONFIRM`, `DB_HELD` and `DB_RELEASE_CONFIRM`.
- `DB_RELEASED` goes to `DB_PRESS_CONFIRM` when the synchronised line reads low.
- `DB_PRESS_CONFIRM` returns to `DB_RELEASED` if the line goes high again before the count ends. If the line stays low for `DEBOUNCE_CYCLES` cycles, it goes to `DB_HELD` and sends out a one-cycle press pulse.
- `DB_HELD` goes to `DB_RELEASE_CONFIRM` when the line reads high.
- `DB_RELEASE_CONFIRM` returns to `DB_HELD` if the line goes low again before the count ends. If the line stays high for `DEBOUNCE_CYCLES` cycles, it goes to `DB_RELEASED`.

The digit register is written by a single clocked process. That process first picks one action from the pulses: `ACT_CLEAR`, `ACT_SHIFT`, `ACT_INC`, `ACT_DEC` or `ACT_NONE`.

A scan counter enables one digit at a time for `SCAN_CYCLES` clock cycles each. About 100,000 cycles gives roughly 1 kHz per digit at 100 MHz. The segment pattern of the enabled digit is decoded from its BCD value, and any code above 9 is blanked.

Top module: `key_digit_entry`

## Requirements
- R1: While `clr` is high at a clock edge, all four digits read 0 after that edge, whatever the key inputs are doing, and no key action taken during the clear appears afterwards.
- R2: A debounced press of the increment key (`key_n[0]`) adds one to the rightmost digit (`digits_o[3:0]`) and leaves the other three digits unchanged.
- R3: Incrementing a rightmost digit that holds 9 gives 0, with no carry into `digits_o[7:4]`.
- R4: A debounced press of the decrement key (`key_n[1]`) subtracts one from the rightmost digit and leaves the other three digits unchanged.
- R5: Decrementing a rightmost digit that holds 0 gives 9, with no borrow from `digits_o[7:4]`.
- R6: A debounced press of the shift key (`key_n[2]`) moves each digit one position to the left. The old leftmost digit (`digits_o[15:12]`) is discarded and the rightmost digit becomes 0.
- R7: A key line held low for fewer than `DEBOUNCE_CYCLES` cycles changes nothing. A press held low for any longer time produces exactly one action.
- R8: When presses are recognised in the same cycle, shift takes priority over increment and increment takes priority over decrement. Only the winning action is applied.
- R9: `dig_en_o` is one-hot at all times outside clear. Its active bit stays for `SCAN_CYCLES` cycles and then moves from bit i to bit i+1 modulo 4. Bit 0 selects the rightmost digit.
- R10: `seg_o` carries the pattern of the digit selected by `dig_en_o`, active high, with bit 0 = segment a through bit 6 = segment g. The patterns for 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F (hex).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr | input | 1 | Synchronous clear, active high |
| key_n | input | 3 | Raw active-low keys: bit 0 increment, bit 1 decrement, bit 2 shift |
| digits_o | output | 16 | Four BCD digits, bits 3:0 rightmost |
| seg_o | output | 7 | Segment pattern of the enabled digit, bit 0 = a |
| dig_en_o | output | 4 | One-hot digit enable, bit 0 = rightmost |

## Verification
The hardest situation to reach is two presses recognised in the same cycle, because each key passes through its own synchroniser and debounce counter. The bench drives both key lines low on the same falling clock edge. The two conditioners are identical, so their pulses line up exactly, and the bench can then see at the digit outputs that only the higher-priority action was applied. Bounce is covered by low glitches shorter than the debounce window, and clear override by holding a key low for the whole time the clear is high.

// File: rtl/key_entry_pkg.sv
package key_entry_pkg;

    localparam int BCD_W     = 4;
    localparam int SEG_W     = 7;
    localparam int NUM_KEYS  = 3;
    localparam int KEY_INC   = 0;
    localparam int KEY_DEC   = 1;
    localparam int KEY_SHIFT = 2;

    typedef logic [BCD_W-1:0] bcd_t;

    typedef enum logic [1:0] {
        DB_RELEASED,
        DB_PRESS_CONFIRM,
        DB_HELD,
        DB_RELEASE_CONFIRM
    } db_state_t;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_CLEAR,
        ACT_SHIFT,
        ACT_INC,
        ACT_DEC
    } edit_act_t;

    // Active-high segment pattern, bit 0 = a ... bit 6 = g; codes above 9 blank.
    function automatic logic [SEG_W-1:0] bcd_to_seg(input bcd_t v);
        logic [SEG_W-1:0] s;
        case (v)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

    function automatic bcd_t bcd_up(input bcd_t v);
        return (v >= 4'd9) ? 4'd0 : v + 4'd1;
    endfunction

    function automatic bcd_t bcd_down(input bcd_t v);
        return (v == 4'd0 || v > 4'd9) ? 4'd9 : v - 4'd1;
    endfunction

endpackage

// File: rtl/key_debounce.sv
module key_debounce
    import key_entry_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic clr,
    input  logic key_n_i,
    output logic press_o
);

    localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_CYCLES - 1);

    logic [1:0]       sync_q;
    logic             level_n;
    db_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             fire;

    always_ff @(posedge clk) begin
        if (clr) sync_q <= 2'b11;
        else     sync_q <= {sync_q[0], key_n_i};
    end

    assign level_n = sync_q[1];

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        unique case (state_q)
            DB_RELEASED: begin
                if (!level_n) begin
                    state_d = DB_PRESS_CONFIRM;
                    cnt_d   = '0;
                end
            end
            DB_PRESS_CONFIRM: begin
                if (level_n) begin
                    state_d = DB_RELEASED;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = DB_HELD;
                    fire    = 1'b1;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            DB_HELD: begin
                if (level_n) begin
                    state_d = DB_RELEASE_CONFIRM;
                    cnt_d   = '0;
                end
            end
            DB_RELEASE_CONFIRM: begin
                if (!level_n) begin
                    state_d = DB_HELD;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = DB_RELEASED;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: state_d = DB_RELEASED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= DB_RELEASED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (clr) press_o <= 1'b0;
        else     press_o <= fire;
    end

endmodule

// File: rtl/digit_editor.sv
module digit_editor
    import key_entry_pkg::*;
#(
    parameter int NUM_DIGITS = 4
) (
    input  logic                                clk,
    input  logic                                clr,
    input  logic [NUM_KEYS-1:0]                 press_i,
    output logic [NUM_DIGITS-1:0][BCD_W-1:0]    digits_o
);

    edit_act_t act;
    logic [NUM_DIGITS-1:0][BCD_W-1:0] digits_q;

    // Clear first, then shift, increment, decrement.
    always_comb begin
        if (clr)                     act = ACT_CLEAR;
        else if (press_i[KEY_SHIFT]) act = ACT_SHIFT;
        else if (press_i[KEY_INC])   act = ACT_INC;
        else if (press_i[KEY_DEC])   act = ACT_DEC;
        else                         act = ACT_NONE;
    end

    // Single writer for every digit.
    always_ff @(posedge clk) begin
        unique case (act)
            ACT_CLEAR: digits_q    <= '0;
            ACT_SHIFT: digits_q    <= {digits_q[NUM_DIGITS-2:0], BCD_W'(0)};
            ACT_INC:   digits_q[0] <= bcd_up(digits_q[0]);
            ACT_DEC:   digits_q[0] <= bcd_down(digits_q[0]);
            ACT_NONE:  digits_q    <= digits_q;
            default:   digits_q    <= digits_q;
        endcase
    end

    assign digits_o = digits_q;

endmodule

// File: rtl/display_scan.sv
module display_scan
    import key_entry_pkg::*;
#(
    parameter int NUM_DIGITS  = 4,
    parameter int SCAN_CYCLES = 100_000
) (
    input  logic                             clk,
    input  logic                             clr,
    input  logic [NUM_DIGITS-1:0][BCD_W-1:0] digits_i,
    output logic [SEG_W-1:0]                 seg_o,
    output logic [NUM_DIGITS-1:0]            dig_en_o
);

    localparam int SCAN_W = $clog2(SCAN_CYCLES + 1);
    localparam int IDX_W  = $clog2(NUM_DIGITS);
    localparam logic [SCAN_W-1:0] SCAN_LAST = SCAN_W'(SCAN_CYCLES - 1);
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(NUM_DIGITS - 1);

    logic [SCAN_W-1:0] tick_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            tick_q <= '0;
            idx_q  <= '0;
        end else if (tick_q == SCAN_LAST) begin
            tick_q <= '0;
            idx_q  <= (idx_q == IDX_LAST) ? '0 : idx_q + IDX_W'(1);
        end else begin
            tick_q <= tick_q + SCAN_W'(1);
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_DIGITS; g++) begin : g_en
            assign dig_en_o[g] = (idx_q == IDX_W'(g));
        end
    endgenerate

    assign seg_o = bcd_to_seg(digits_i[idx_q]);

endmodule

// File: rtl/key_digit_entry.sv
module key_digit_entry
    import key_entry_pkg::*;
#(
    parameter int DEBOUNCE_CYCLES = 1_000_000,
    parameter int SCAN_CYCLES     = 100_000,
    parameter int NUM_DIGITS      = 4
) (
    input  logic                          clk,
    input  logic                          clr,
    input  logic [NUM_KEYS-1:0]           key_n,
    output logic [NUM_DIGITS*BCD_W-1:0]   digits_o,
    output logic [SEG_W-1:0]              seg_o,
    output logic [NUM_DIGITS-1:0]         dig_en_o
);

    logic [NUM_KEYS-1:0]              press_pulse;
    logic [NUM_DIGITS-1:0][BCD_W-1:0] digit_vec;

    genvar k;
    generate
        for (k = 0; k < NUM_KEYS; k++) begin : g_key
            key_debounce #(
                .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)
            ) u_deb (
                .clk    (clk),
                .clr    (clr),
                .key_n_i(key_n[k]),
                .press_o(press_pulse[k])
            );
        end
    endgenerate

    digit_editor #(
        .NUM_DIGITS(NUM_DIGITS)
    ) u_edit (
        .clk     (clk),
        .clr     (clr),
        .press_i (press_pulse),
        .digits_o(digit_vec)
    );

    display_scan #(
        .NUM_DIGITS (NUM_DIGITS),
        .SCAN_CYCLES(SCAN_CYCLES)
    ) u_scan (
        .clk     (clk),
        .clr     (clr),
        .digits_i(digit_vec),
        .seg_o   (seg_o),
        .dig_en_o(dig_en_o)
    );

    assign digits_o = digit_vec;

endmodule

// File: rtl/key_digit_entry_chk.sv
module key_digit_entry_chk #(
    parameter int NUM_DIGITS = 4
) (
    input logic                    clk,
    input logic                    clr,
    input logic [NUM_DIGITS*4-1:0] digits,
    input logic [2:0]              press,
    input logic [NUM_DIGITS-1:0]   dig_en
);

    localparam int W = NUM_DIGITS * 4;

    a_r1_clear_zero: assert property (@(posedge clk)
        clr |=> digits == '0);

    a_r2_inc_step: assert property (@(posedge clk) disable iff (clr)
        (press == 3'b001 && digits[3:0] != 4'd9) |=>
        (digits[3:0] == $past(digits[3:0]) + 4'd1 && digits[W-1:4] == $past(digits[W-1:4])));

    a_r3_inc_wrap: assert property (@(posedge clk) disable iff (clr)
        (press == 3'b001 && digits[3:0] == 4'd9) |=>
        (digits[3:0] == 4'd0 && digits[W-1:4] == $past(digits[W-1:4])));

    a_r4_dec_step: assert property (@(posedge clk) disable iff (clr)
        (press == 3'b010 && digits[3:0] != 4'd0) |=>
        (digits[3:0] == $past(digits[3:0]) - 4'd1 && digits[W-1:4] == $past(digits[W-1:4])));

    a_r5_dec_wrap: assert property (@(posedge clk) disable iff (clr)
        (press == 3'b010 && digits[3:0] == 4'd0) |=>
        (digits[3:0] == 4'd9 && digits[W-1:4] == $past(digits[W-1:4])));

    a_r6_shift_left: assert property (@(posedge clk) disable iff (clr)
        (press == 3'b100) |=> digits == {$past(digits[W-5:0]), 4'd0});

    a_r7_idle_hold: assert property (@(posedge clk) disable iff (clr)
        (press == 3'b000) |=> $stable(digits));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (clr)
        (press != 3'b000) |=> (press & $past(press)) == 3'b000);

    a_r8_shift_wins: assert property (@(posedge clk) disable iff (clr)
        (press[2] && press[1:0] != 2'b00) |=> digits == {$past(digits[W-5:0]), 4'd0});

    a_r8_inc_over_dec: assert property (@(posedge clk) disable iff (clr)
        (press == 3'b011 && digits[3:0] != 4'd9) |=>
        digits[3:0] == $past(digits[3:0]) + 4'd1);

    a_r9_onehot_enable: assert property (@(posedge clk) disable iff (clr)
        $onehot(dig_en));

endmodule

bind key_digit_entry key_digit_entry_chk #(.NUM_DIGITS(NUM_DIGITS)) chk_i (
    .clk   (clk),
    .clr   (clr),
    .digits(digits_o),
    .press (press_pulse),
    .dig_en(dig_en_o)
);

// File: tb/key_digit_entry_tb_top.sv
module key_digit_entry_tb_top;

    localparam int DEB  = 8;
    localparam int SCAN = 4;
    localparam int WAIT = DEB + 8;

    logic        clk = 1'b0;
    logic        clr = 1'b1;
    logic [2:0]  key_n = 3'b111;
    logic [15:0] digits_o;
    logic [6:0]  seg_o;
    logic [3:0]  dig_en_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    key_digit_entry #(
        .DEBOUNCE_CYCLES(DEB),
        .SCAN_CYCLES    (SCAN),
        .NUM_DIGITS     (4)
    ) dut_i (
        .clk     (clk),
        .clr     (clr),
        .key_n   (key_n),
        .digits_o(digits_o),
        .seg_o   (seg_o),
        .dig_en_o(dig_en_o)
    );

    function automatic logic [6:0] ref_seg(input logic [3:0] v);
        case (v)
            4'd0: return 7'h3F;  4'd1: return 7'h06;  4'd2: return 7'h5B;
            4'd3: return 7'h4F;  4'd4: return 7'h66;  4'd5: return 7'h6D;
            4'd6: return 7'h7D;  4'd7: return 7'h07;  4'd8: return 7'h7F;
            4'd9: return 7'h6F;  default: return 7'h00;
        endcase
    endfunction

    task automatic check_val(input logic [15:0] exp, input string req);
        tests++;
        if (digits_o !== exp) begin
            fails++;
            $display("FAIL %s digits actual=%h expected=%h", req, digits_o, exp);
        end
    endtask

    task automatic press(input logic [2:0] mask);
        @(negedge clk) key_n = ~mask;
        repeat (WAIT) @(negedge clk);
        key_n = 3'b111;
        repeat (WAIT) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        clr = 1'b0;
        @(negedge clk);
        check_val(16'h0000, "R1");
    endtask

    task automatic t_increment;
        repeat (3) press(3'b001);
        check_val(16'h0003, "R2");
        repeat (6) press(3'b001);
        check_val(16'h0009, "R2");
        press(3'b001);
        check_val(16'h0000, "R3");
    endtask

    task automatic t_decrement;
        press(3'b010);
        check_val(16'h0009, "R5");
        press(3'b010);
        check_val(16'h0008, "R4");
    endtask

    task automatic t_shift;
        press(3'b100);
        check_val(16'h0080, "R6");
        repeat (2) press(3'b001);
        check_val(16'h0082, "R2");
        press(3'b100);
        check_val(16'h0820, "R6");
        press(3'b100);
        check_val(16'h8200, "R6");
        press(3'b100);
        check_val(16'h2000, "R6");
    endtask

    task automatic t_bounce;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) key_n = 3'b110;
            repeat (3) @(negedge clk);
            key_n = 3'b111;
            repeat (3) @(negedge clk);
        end
        repeat (WAIT) @(negedge clk);
        check_val(16'h2000, "R7");
        @(negedge clk) key_n = 3'b110;
        repeat (4 * DEB) @(negedge clk);
        key_n = 3'b111;
        repeat (WAIT) @(negedge clk);
        check_val(16'h2001, "R7");
    endtask

    task automatic t_priority;
        press(3'b101);
        check_val(16'h0010, "R8");
        press(3'b011);
        check_val(16'h0011, "R8");
        press(3'b110);
        check_val(16'h0110, "R8");
    endtask

    task automatic t_scan;
        logic [3:0] prev_en;
        int prev_idx;
        int run_len;
        bit seen;
        repeat (5) press(3'b001);
        check_val(16'h0115, "R2");
        prev_en  = dig_en_o;
        prev_idx = 0;
        run_len  = 0;
        seen     = 1'b0;
        for (int c = 0; c < 10 * SCAN; c++) begin
            @(negedge clk);
            tests++;
            if (!$onehot(dig_en_o)) begin
                fails++;
                $display("FAIL R9 dig_en actual=%b expected=one-hot", dig_en_o);
            end else begin
                int idx = 0;
                for (int b = 0; b < 4; b++) if (dig_en_o[b]) idx = b;
                tests++;
                if (seg_o !== ref_seg(digits_o[idx*4 +: 4])) begin
                    fails++;
                    $display("FAIL R10 seg actual=%h expected=%h", seg_o, ref_seg(digits_o[idx*4 +: 4]));
                end
                if (dig_en_o != prev_en) begin
                    if (seen) begin
                        tests++;
                        if (run_len != SCAN || idx != (prev_idx + 1) % 4) begin
                            fails++;
                            $display("FAIL R9 dwell/index actual=%0d/%0d expected=%0d/%0d",
                                     run_len, idx, SCAN, (prev_idx + 1) % 4);
                        end
                    end
                    seen    = 1'b1;
                    run_len = 1;
                end else begin
                    run_len++;
                end
                prev_idx = idx;
                prev_en  = dig_en_o;
            end
        end
    endtask

    task automatic t_clear_override;
        @(negedge clk) key_n = 3'b110;
        clr = 1'b1;
        repeat (3 * DEB) @(negedge clk);
        key_n = 3'b111;
        repeat (2) @(negedge clk);
        clr = 1'b0;
        repeat (WAIT) @(negedge clk);
        check_val(16'h0000, "R1");
    endtask

    initial begin
        t_reset();
        t_increment();
        t_decrement();
        t_shift();
        t_bounce();
        t_priority();
        t_scan();
        t_clear_override();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100_000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule